// File: doc/BRIEF.md
# Masked repeating alarm comparator

This block watches a calendar clock and raises an alarm when the clock agrees with a stored alarm time. A 4-bit mask code sets how coarse the comparison is. At one end it fires every half second. At the other end it fires once a year, when month, day, hour, minute, second and the half-second phase all agree. The time counters sit outside the block. It receives their present values as BCD fields together with a strobe that pulses once per half second. It compares the fields only in a cycle where that strobe is high.

Software loads the alarm time through a two-byte window. A 2-bit pointer picks one of four field pairs. A write to the high byte of a pair moves the pointer down by one, so a run of writes walks month/day, then weekday/hour, then minute/second. Each alarm may be followed by further alarms. A repeat count says how many more are allowed. With the chime bit set, the alarm never disarms and the count simply wraps. The enable bit and the repeat count are visible as outputs.

Top module: `alarm_match`

## Requirements
- R1: After reset, alarm_o, alarm_en and rpt_cnt are 0. The pointer is 0, every alarm field is 0, chime is 0 and the mask code is 0.
- R2: A comparison happens only in a cycle with half_tick high and alarm_en high. A hit drives alarm_o high for exactly the one cycle after that strobe cycle. Without the strobe, or with the enable low, alarm_o stays low.
- R3: The mask codes and the fields each one needs to agree are as follows. Every field listed for a code must be equal. Code 0 needs nothing. Code 1 needs cur_half = 0. Code 2 adds the low BCD digit of seconds. Code 3 needs the full seconds byte. Code 4 adds the low digit of minutes. Code 5 needs the full minutes byte. Code 6 adds hours. Code 7 adds the weekday (3 bits). Code 8 is code 6 plus the day byte, with the weekday ignored. Code 9 adds the month byte to code 8.
- R4: Mask codes 10 to 15 never produce an alarm, and the enable and the count are left unchanged.
- R5: An alarm with chime = 0 and a repeat count of 0 clears alarm_en. Outside of alarms and config writes, alarm_en holds its value.
- R6: An alarm with chime = 0 and a nonzero count decrements the count and leaves alarm_en set, so a count of N yields N+1 alarms.
- R7: With chime = 1, every alarm leaves alarm_en set and decrements the count. A count of 0 wraps to its all-ones value.
- R8: The window pointer selects pairs as high/low: 2 is month/day, 1 is weekday/hour, 0 is minute/second, and 3 holds nothing, so writes there change no field. A write with win_hi = 1 decrements the pointer modulo 4.
- R9: ptr_we loads the pointer from ptr_wdata. It takes precedence over the decrement in the same cycle.
- R10: In the same cycle as an alarm, a config write sets the enable, chime and mask, and a repeat write sets the count. Each overrides the alarm's own update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | One-cycle strobe per half second |
| cur_half | input | 1 | 0 in first half of the second, 1 in second half |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_wday | input | 3 | Current weekday |
| cur_day | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| ptr_we | input | 1 | Load window pointer |
| ptr_wdata | input | 2 | New pointer value |
| win_we | input | 1 | Write to the selected pair |
| win_hi | input | 1 | 1 selects the high byte, 0 the low byte |
| win_wdata | input | 8 | Window write data |
| cfg_we | input | 1 | Write enable, chime and mask |
| cfg_en | input | 1 | New enable value |
| cfg_chime | input | 1 | New chime value |
| cfg_mask | input | 4 | New mask code |
| rpt_we | input | 1 | Write repeat count |
| rpt_wdata | input | RPT_W | New repeat count |
| alarm_o | output | 1 | One-cycle alarm pulse |
| alarm_en | output | 1 | Current enable |
| rpt_cnt | output | RPT_W | Current repeat count |

## Verification
For every mask code, the bench first makes the clock agree with the alarm. It then breaks exactly the digit that the code adds over the code below it. A decoder that takes one field too many or too few therefore either fires when it should not or stays silent. For code 8, only the day byte is disturbed. This shows whether a decoder wrongly pulls in the weekday or drops the day. The pointer is walked through all four positions and then wraps. A write that lands at position 3, or a decrement that goes the wrong way, corrupts a field the yearly alarm depends on. The bench also covers the repeat count ending at zero, the chime count wrapping from 0, and config writes in the same cycle as an alarm. A design that gets the order of updates wrong disarms when it should stay armed, or loses the written count.

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int RPT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_tick,
  input  logic             cur_half,
  input  logic [7:0]       cur_sec,
  input  logic [7:0]       cur_min,
  input  logic [7:0]       cur_hour,
  input  logic [2:0]       cur_wday,
  input  logic [7:0]       cur_day,
  input  logic [7:0]       cur_mon,
  input  logic             ptr_we,
  input  logic [1:0]       ptr_wdata,
  input  logic             win_we,
  input  logic             win_hi,
  input  logic [7:0]       win_wdata,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic             cfg_chime,
  input  logic [3:0]       cfg_mask,
  input  logic             rpt_we,
  input  logic [RPT_W-1:0] rpt_wdata,
  output logic             alarm_o,
  output logic             alarm_en,
  output logic [RPT_W-1:0] rpt_cnt
);

  logic [1:0]       ptr;
  logic [7:0]       a_sec, a_min, a_hour, a_day, a_mon;
  logic [2:0]       a_wday;
  logic             chime;
  logic [3:0]       mask;
  logic             en_q, pulse_q;
  logic [RPT_W-1:0] rpt_q;
  logic             hit;

  wire m_half = ~cur_half;
  wire m_sec1 = cur_sec[3:0] == a_sec[3:0];
  wire m_sec  = cur_sec == a_sec;
  wire m_min1 = cur_min[3:0] == a_min[3:0];
  wire m_min  = cur_min == a_min;
  wire m_hour = cur_hour == a_hour;
  wire m_wday = cur_wday == a_wday;
  wire m_day  = cur_day == a_day;
  wire m_mon  = cur_mon == a_mon;
  wire m_hms  = m_half & m_sec & m_min & m_hour;

  always_comb begin
    case (mask)
      4'd0:    hit = 1'b1;
      4'd1:    hit = m_half;
      4'd2:    hit = m_half & m_sec1;
      4'd3:    hit = m_half & m_sec;
      4'd4:    hit = m_half & m_sec & m_min1;
      4'd5:    hit = m_half & m_sec & m_min;
      4'd6:    hit = m_hms;
      4'd7:    hit = m_hms & m_wday;
      4'd8:    hit = m_hms & m_day;
      4'd9:    hit = m_hms & m_day & m_mon;
      default: hit = 1'b0;
    endcase
  end

  wire fire = half_tick & en_q & hit;
  wire last = ~chime & (rpt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      a_sec <= '0; a_min <= '0; a_hour <= '0;
      a_wday <= '0; a_day <= '0; a_mon <= '0;
    end else begin
      if (ptr_we)                ptr <= ptr_wdata;
      else if (win_we && win_hi) ptr <= ptr - 2'd1;
      if (win_we) begin
        case (ptr)
          2'd0: if (win_hi) a_min <= win_wdata;       else a_sec  <= win_wdata;
          2'd1: if (win_hi) a_wday <= win_wdata[2:0]; else a_hour <= win_wdata;
          2'd2: if (win_hi) a_mon <= win_wdata;       else a_day  <= win_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; chime <= 1'b0; mask <= '0;
      rpt_q <= '0; pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (cfg_we) begin
        en_q  <= cfg_en;
        chime <= cfg_chime;
        mask  <= cfg_mask;
      end else if (fire && last) begin
        en_q <= 1'b0;
      end
      if (rpt_we)             rpt_q <= rpt_wdata;
      else if (fire && !last) rpt_q <= rpt_q - 1'b1;
    end
  end

  assign alarm_o  = pulse_q;
  assign alarm_en = en_q;
  assign rpt_cnt  = rpt_q;

endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk #(
  parameter int RPT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             half_tick,
  input logic             cfg_we,
  input logic             rpt_we,
  input logic             chime,
  input logic [3:0]       mask,
  input logic             alarm_o,
  input logic             alarm_en,
  input logic [RPT_W-1:0] rpt_cnt
);

  p_pulse_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> $past(half_tick) && $past(alarm_en));

  p_bad_mask_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> $past(mask) < 4'd10);

  p_oneshot_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && !$past(cfg_we) && !$past(chime) && $past(rpt_cnt) == '0) |-> !alarm_en);

  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_o && !$past(cfg_we)) |-> $stable(alarm_en));

  p_repeat_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && !$past(rpt_we) && $past(rpt_cnt) != '0) |->
      rpt_cnt == RPT_W'($past(rpt_cnt) - 1'b1));

  p_chime_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && $past(chime) && !$past(cfg_we)) |-> alarm_en);

endmodule

bind alarm_match alarm_match_chk #(.RPT_W(RPT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .cfg_we(cfg_we),
  .rpt_we(rpt_we), .chime(chime), .mask(mask), .alarm_o(alarm_o),
  .alarm_en(alarm_en), .rpt_cnt(rpt_cnt)
);

// File: tb/tb_alarm_match.sv
`timescale 1ns/100ps
module tb_alarm_match;
  localparam int RPT_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, half_tick, cur_half, ptr_we, win_we, win_hi, cfg_we, cfg_en, cfg_chime, rpt_we;
  logic [7:0] cur_sec, cur_min, cur_hour, cur_day, cur_mon, win_wdata;
  logic [2:0] cur_wday;
  logic [1:0] ptr_wdata;
  logic [3:0] cfg_mask;
  logic [RPT_W-1:0] rpt_wdata;
  logic alarm_o, alarm_en;
  logic [RPT_W-1:0] rpt_cnt;

  alarm_match #(.RPT_W(RPT_W)) dut (.*);

  int n_cmp = 0, n_bad = 0;

  logic [1:0] m_ptr;
  logic [7:0] m_sec, m_min, m_hour, m_day, m_mon;
  logic [2:0] m_wday;
  logic m_chime, m_en;
  logic [3:0] m_mask;
  logic [RPT_W-1:0] m_rpt;

  function automatic bit exp_hit(input logic [3:0] mk);
    bit h = (cur_half == 1'b0);
    bit s = h && cur_sec == m_sec;
    bit n = s && cur_min == m_min;
    bit d = n && cur_hour == m_hour;
    case (mk)
      4'd0: return 1'b1;
      4'd1: return h;
      4'd2: return h && cur_sec[3:0] == m_sec[3:0];
      4'd3: return s;
      4'd4: return s && cur_min[3:0] == m_min[3:0];
      4'd5: return n;
      4'd6: return d;
      4'd7: return d && cur_wday == m_wday;
      4'd8: return d && cur_day == m_day;
      4'd9: return d && cur_day == m_day && cur_mon == m_mon;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    half_tick = 0; ptr_we = 0; win_we = 0; win_hi = 0; cfg_we = 0; rpt_we = 0;
  endtask

  task automatic step(input string tag);
    bit f = half_tick && m_en && exp_hit(m_mask);
    bit lst = !m_chime && m_rpt == '0;
    @(posedge clk); #1;
    if (win_we) begin
      case (m_ptr)
        2'd0: if (win_hi) m_min = win_wdata;       else m_sec  = win_wdata;
        2'd1: if (win_hi) m_wday = win_wdata[2:0]; else m_hour = win_wdata;
        2'd2: if (win_hi) m_mon = win_wdata;       else m_day  = win_wdata;
        default: ;
      endcase
    end
    if (ptr_we) m_ptr = ptr_wdata;
    else if (win_we && win_hi) m_ptr = m_ptr - 2'd1;
    if (cfg_we) begin m_en = cfg_en; m_chime = cfg_chime; m_mask = cfg_mask; end
    else if (f && lst) m_en = 1'b0;
    if (rpt_we) m_rpt = rpt_wdata;
    else if (f && !lst) m_rpt = m_rpt - 1'b1;
    chk(tag, alarm_o, f);
    chk(tag, alarm_en, m_en);
    chk(tag, rpt_cnt, m_rpt);
    idle_inputs();
  endtask

  task automatic wr_ptr(input logic [1:0] p);
    ptr_we = 1; ptr_wdata = p; step("R9");
  endtask
  task automatic wr_win(input logic hi, input logic [7:0] d);
    win_we = 1; win_hi = hi; win_wdata = d; step("R8");
  endtask
  task automatic wr_cfg(input logic e, input logic c, input logic [3:0] mk);
    cfg_we = 1; cfg_en = e; cfg_chime = c; cfg_mask = mk; step("R10");
  endtask
  task automatic wr_rpt(input logic [RPT_W-1:0] v);
    rpt_we = 1; rpt_wdata = v; step("R6");
  endtask
  task automatic tick(input string tag);
    half_tick = 1; step(tag);
  endtask
  task automatic match_time();
    cur_half = 0; cur_sec = m_sec; cur_min = m_min; cur_hour = m_hour;
    cur_wday = m_wday; cur_day = m_day; cur_mon = m_mon;
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    rst_n = 0; cur_half = 0; cur_sec = 0; cur_min = 0; cur_hour = 0; cur_wday = 0;
    cur_day = 0; cur_mon = 0; ptr_wdata = 0; win_wdata = 0; cfg_en = 0; cfg_chime = 0;
    cfg_mask = 0; rpt_wdata = 0;
    m_ptr = 0; m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0; m_day = 0; m_mon = 0;
    m_chime = 0; m_en = 0; m_mask = 0; m_rpt = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", alarm_o, 0); chk("R1", alarm_en, 0); chk("R1", rpt_cnt, 0);
    rst_n = 1;
    // R1: all-zero alarm fields with mask 9 match an all-zero clock
    cfg_we = 1; cfg_en = 1; cfg_chime = 0; cfg_mask = 4'd9; step("R1");
    tick("R1");

    // R8/R9 window walk
    wr_ptr(2'd2);
    wr_win(0, 8'h15); wr_win(1, 8'h06);
    wr_win(0, 8'h12); wr_win(1, 8'h03);
    wr_win(0, 8'h30); wr_win(1, 8'h45);
    wr_win(0, 8'hAA); wr_win(1, 8'hBB);
    match_time();
    wr_cfg(1, 0, 4'd9);
    tick("R8");
    wr_win(0, 8'h16);
    wr_cfg(1, 0, 4'd9);
    tick("R8");
    cur_day = 8'h16;
    tick("R8");

    // R2
    wr_cfg(1, 0, 4'd0);
    step("R2"); step("R2");
    wr_cfg(0, 0, 4'd0);
    tick("R2");

    // R4
    match_time();
    for (int k = 10; k < 16; k++) begin
      wr_cfg(1, 0, 4'(k));
      tick("R4");
    end

    // R3 per-code digit break
    for (int k = 1; k < 10; k++) begin
      wr_cfg(1, 1, 4'(k));
      match_time();
      tick("R3");
      step("R3");
      case (k)
        1: cur_half = 1;
        2: cur_sec[3:0] = cur_sec[3:0] + 1;
        3: cur_sec[7:4] = cur_sec[7:4] + 1;
        4: cur_min[3:0] = cur_min[3:0] + 1;
        5: cur_min[7:4] = cur_min[7:4] + 1;
        6: cur_hour = cur_hour + 1;
        7: cur_wday = cur_wday + 1;
        8: cur_day = cur_day + 1;
        default: cur_mon = cur_mon + 1;
      endcase
      tick("R3");
    end
    match_time(); cur_wday = cur_wday + 1;
    wr_cfg(1, 0, 4'd8);
    tick("R3");

    // R5 one-shot
    wr_rpt(0);
    wr_cfg(1, 0, 4'd0);
    tick("R5"); tick("R5");

    // R6 counted repeat
    wr_cfg(1, 0, 4'd0);
    wr_rpt(2);
    tick("R6"); tick("R6"); tick("R6"); tick("R6");

    // R7 chime wrap
    wr_cfg(1, 1, 4'd0);
    wr_rpt(0);
    tick("R7"); tick("R7");

    // R10 same-cycle writes
    wr_cfg(1, 0, 4'd0);
    wr_rpt(0);
    half_tick = 1; cfg_we = 1; cfg_en = 1; cfg_chime = 0; cfg_mask = 0; step("R10");
    wr_cfg(1, 1, 4'd0);
    half_tick = 1; rpt_we = 1; rpt_wdata = 8'd5; step("R10");

    // random phase
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 19);
      if (r == 0) begin
        wr_cfg($urandom_range(0, 7) != 0, 1'($urandom), 4'($urandom_range(0, 15)));
      end else if (r == 1) begin
        wr_rpt(RPT_W'($urandom_range(0, 3)));
      end else if (r == 2) begin
        if ($urandom_range(0, 1) == 0) wr_ptr(2'($urandom));
        else wr_win(1'($urandom), 8'($urandom));
      end else begin
        cur_half = 1'($urandom);
        cur_sec  = ($urandom_range(0, 3) != 0) ? m_sec  : 8'($urandom);
        cur_min  = ($urandom_range(0, 3) != 0) ? m_min  : 8'($urandom);
        cur_hour = ($urandom_range(0, 3) != 0) ? m_hour : 8'($urandom);
        cur_wday = ($urandom_range(0, 3) != 0) ? m_wday : 3'($urandom);
        cur_day  = ($urandom_range(0, 3) != 0) ? m_day  : 8'($urandom);
        cur_mon  = ($urandom_range(0, 3) != 0) ? m_mon  : 8'($urandom);
        half_tick = ($urandom_range(0, 1) == 0);
        if (m_mask < 4'd10) step("R3"); else step("R4");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule